// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them in a fixed order, and signals a processor when a request needs service. Software reaches it through two byte ports. Port 0 takes command bytes and returns status. Port 1 holds the mask. Before it raises its output, the block must receive a setup sequence. That sequence picks edge-latched or level-followed requests and says whether the cascade word is present and whether a mode word follows.

Software acknowledges by polling. A command byte arms a poll, and the next status read returns the winning level. That same read marks the level as in service and drops its latched request. Software later releases the level with a specific or non-specific end-of-interrupt command. When a poll finds nothing, it reports level 7 with the valid flag clear and no in-service bit set. Software can then read the in-service register back to tell a real level-7 request from a spurious one. Port 0 reads return the request register or the in-service register, whichever was last selected by a command byte.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads back 0xFF on port 1, port-0 reads return the request register, and `irq_out` stays low until a setup sequence has completed, even when the mask is opened before setup.
- R2: A port-0 write with bit 4 set starts setup. It clears the mask, the in-service register, the request register and any armed poll, and selects request readback. Bit 3 picks level mode (1) or edge mode (0), bit 1 means the cascade word is skipped, and bit 0 means a mode word follows. The following port-1 writes are taken as the base word, the cascade word (unless skipped) and the mode word (if required). Only the next port-1 write after that loads the mask.
- R3: Outside setup, a port-1 write loads the mask and a port-1 read returns it. A mask bit of 1 blocks the matching input from being presented or polled.
- R4: In edge mode a request bit is latched on a rising input, and it is cleared when a poll acknowledges it. An input held high does not latch again.
- R5: In level mode the request bit follows the input one cycle later, and a poll acknowledge does not clear it.
- R6: Priority is fixed, with input 0 highest. `irq_out` is high exactly when setup is complete and an unmasked request exists at a level above every level in service. A level already in service blocks itself and all lower levels.
- R7: Writing 0x0C to port 0 arms a poll. The next port-0 read returns 0x80 plus the winning level, sets that level's in-service bit and, in edge mode, clears its request. The read after that returns the selected register again.
- R8: A poll with no valid winner returns 0x07 and leaves the in-service register unchanged, so an in-service readback shows bit 7 clear.
- R9: Writing 0x60 plus n to port 0 clears in-service bit n only.
- R10: Writing 0x20 to port 0 clears the highest-priority (lowest-numbered) in-service bit.
- R11: Writing 0x0A to port 0 selects the request register and 0x0B selects the in-service register for later port-0 reads. The selection stays in force across reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Port select: 0 command/status, 1 mask |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, side effects at the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the current select, valid in the strobe cycle |
| irq_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Directed patterns cover several cases. One raises a request below a level already in service and then one above it, which separates nested blocking from plain lowest-index selection. Another holds an input high across setup and across acknowledge, which separates edge latching from level following. An empty poll and a real level-7 poll are both run so that the spurious report and the valid flag can be told apart. A specific end-of-interrupt is sent to a level not in service, and a non-specific end-of-interrupt is sent with two levels active, to show that each touches only its own bit. Seeded random runs in both modes then mix input toggles, mask loads, polls, readback selects and both end-of-interrupt forms, and every read and every cycle's `irq_out` is checked against a bench model.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [2:0] {
      ST_RAW,
      ST_W2,
      ST_W3,
      ST_W4,
      ST_RUN
   } init_st_t;

   // command byte field positions that software encodes
   localparam int B_START  = 4;
   localparam int B_OCW3   = 3;
   localparam int B_LEVEL  = 3;
   localparam int B_POLL   = 2;
   localparam int B_RRSEL  = 1;
   localparam int B_RRISR  = 0;
   localparam int B_SINGLE = 1;
   localparam int B_NEED4  = 0;

   localparam logic [2:0] OP_SPEC_EOI = 3'b011;
   localparam logic [2:0] OP_NSPC_EOI = 3'b001;

endpackage

// File: rtl/pic_req.sv
module pic_req #(
   parameter int N_LEVELS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] irq_in,
   input  logic                level_mode,
   input  logic                init_clr,
   input  logic [N_LEVELS-1:0] ack_vec,
   output logic [N_LEVELS-1:0] irr_q
);

   logic [N_LEVELS-1:0] prev_q;

   for (genvar i = 0; i < N_LEVELS; i++) begin : g_line
      logic rise;
      assign rise = irq_in[i] & ~prev_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            irr_q[i]  <= 1'b0;
         end else begin
            prev_q[i] <= irq_in[i];
            if (init_clr)
               irr_q[i] <= 1'b0;
            else if (level_mode)
               irr_q[i] <= irq_in[i];
            else if (rise)
               irr_q[i] <= 1'b1;
            else if (ack_vec[i])
               irr_q[i] <= 1'b0;
         end
      end

      // R4: acknowledged edge request drops unless a new edge arrives
      p_ack_clears_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!level_mode && !init_clr && ack_vec[i] && !rise) |=> !irr_q[i]);
   end

endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
   parameter int N_LEVELS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                init_clr,
   input  logic [N_LEVELS-1:0] set_vec,
   input  logic [N_LEVELS-1:0] clr_vec,
   output logic [N_LEVELS-1:0] isr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         isr_q <= '0;
      else if (init_clr)
         isr_q <= '0;
      else
         isr_q <= (isr_q | set_vec) & ~clr_vec;
   end

   // R7: a poll puts at most one level in service
   p_set_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));

   // R9: a released level is no longer in service
   p_eoi_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec != '0) && (set_vec == '0)) |=> ((isr_q & $past(clr_vec)) == '0));

endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int N_LEVELS = 8,
   parameter int LVL_W    = $clog2(N_LEVELS)
) (
   input  logic [N_LEVELS-1:0] irr,
   input  logic [N_LEVELS-1:0] isr,
   input  logic [N_LEVELS-1:0] mask,
   output logic [N_LEVELS-1:0] win_hot,
   output logic                win_valid,
   output logic [LVL_W-1:0]    win_lvl
);

   logic [N_LEVELS-1:0] pend;
   logic [N_LEVELS-1:0] seen_pend;
   logic [N_LEVELS-1:0] seen_svc;

   assign pend = irr & ~mask;

   // prefix chains: anything pending above, anything in service at or above
   for (genvar i = 0; i < N_LEVELS; i++) begin : g_rank
      if (i == 0) begin : g_top
         assign seen_pend[i] = 1'b0;
         assign seen_svc[i]  = isr[i];
      end else begin : g_rest
         assign seen_pend[i] = seen_pend[i-1] | pend[i-1];
         assign seen_svc[i]  = seen_svc[i-1] | isr[i];
      end
      assign win_hot[i] = pend[i] & ~seen_pend[i] & ~seen_svc[i];
   end

   assign win_valid = |win_hot;

   always_comb begin
      win_lvl = LVL_W'(N_LEVELS - 1);
      for (int k = N_LEVELS - 1; k >= 0; k--) begin
         if (win_hot[k])
            win_lvl = LVL_W'(k);
      end
   end

endmodule

// File: rtl/pic_ctl.sv
module pic_ctl import pic_pkg::*; #(
   parameter int N_LEVELS = 8,
   parameter int DATA_W   = 8,
   parameter int LVL_W    = $clog2(N_LEVELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [N_LEVELS-1:0] irr_q,
   input  logic [N_LEVELS-1:0] isr_q,
   input  logic [N_LEVELS-1:0] win_hot,
   input  logic                win_valid,
   input  logic [LVL_W-1:0]    win_lvl,
   output logic [N_LEVELS-1:0] mask_q,
   output logic                level_mode,
   output logic                init_done,
   output logic                init_clr,
   output logic [N_LEVELS-1:0] ack_vec,
   output logic [N_LEVELS-1:0] isr_clr
);

   init_st_t st_q;
   logic     single_q, need4_q;
   logic     rsel_isr_q;
   logic     poll_q;

   logic wr_cmd, wr_msk, rd_cmd;
   logic is_ocw3, is_ocw2;
   logic poll_take;

   assign wr_cmd  = bus_wr & ~bus_sel;
   assign wr_msk  = bus_wr & bus_sel;
   assign rd_cmd  = bus_rd & ~bus_sel & ~bus_wr;

   assign init_clr = wr_cmd & bus_wdata[B_START];
   assign is_ocw3  = wr_cmd & ~bus_wdata[B_START] & bus_wdata[B_OCW3];
   assign is_ocw2  = wr_cmd & ~bus_wdata[B_START] & ~bus_wdata[B_OCW3];

   assign init_done = (st_q == ST_RUN);
   assign poll_take = rd_cmd & poll_q;
   assign ack_vec   = (poll_take && win_valid) ? win_hot : '0;

   // setup sequence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_RAW;
         single_q   <= 1'b0;
         need4_q    <= 1'b0;
         level_mode <= 1'b0;
      end else if (init_clr) begin
         st_q       <= ST_W2;
         single_q   <= bus_wdata[B_SINGLE];
         need4_q    <= bus_wdata[B_NEED4];
         level_mode <= bus_wdata[B_LEVEL];
      end else if (wr_msk) begin
         unique case (st_q)
            ST_W2:   st_q <= single_q ? (need4_q ? ST_W4 : ST_RUN) : ST_W3;
            ST_W3:   st_q <= need4_q ? ST_W4 : ST_RUN;
            ST_W4:   st_q <= ST_RUN;
            default: st_q <= st_q;
         endcase
      end
   end

   // mask register
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '1;
      else if (init_clr)
         mask_q <= '0;
      else if (wr_msk && (st_q == ST_RAW || st_q == ST_RUN))
         mask_q <= bus_wdata[N_LEVELS-1:0];
   end

   // readback select and poll arming
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsel_isr_q <= 1'b0;
         poll_q     <= 1'b0;
      end else if (init_clr) begin
         rsel_isr_q <= 1'b0;
         poll_q     <= 1'b0;
      end else if (is_ocw3) begin
         poll_q <= bus_wdata[B_POLL];
         if (bus_wdata[B_RRSEL])
            rsel_isr_q <= bus_wdata[B_RRISR];
      end else if (poll_take) begin
         poll_q <= 1'b0;
      end
   end

   // end-of-interrupt decode
   always_comb begin
      isr_clr = '0;
      if (is_ocw2) begin
         if (bus_wdata[7:5] == OP_SPEC_EOI)
            isr_clr = {{(N_LEVELS-1){1'b0}}, 1'b1} << bus_wdata[LVL_W-1:0];
         else if (bus_wdata[7:5] == OP_NSPC_EOI)
            isr_clr = isr_q & (~isr_q + 1'b1);
      end
   end

   // read mux
   always_comb begin
      if (bus_sel)
         bus_rdata = mask_q;
      else if (poll_q)
         bus_rdata = {win_valid, {(DATA_W-1-LVL_W){1'b0}}, win_lvl};
      else if (rsel_isr_q)
         bus_rdata = isr_q;
      else
         bus_rdata = irr_q;
   end

   // R7: a poll answers exactly one read
   p_poll_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_take && !bus_wr) |=> !poll_q);

   // R8: an empty poll leaves the in-service register alone
   p_poll_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_take && !win_valid && !bus_wr) |=> (isr_q == $past(isr_q)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_LEVELS = 8,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [N_LEVELS-1:0] irq_in,
   output logic                irq_out
);

   localparam int LVL_W = $clog2(N_LEVELS);

   if (N_LEVELS != 8 || DATA_W != 8) begin : g_bad_cfg
      $error("prio_irq_ctrl: command codes need 8 levels and byte data");
   end

   logic [N_LEVELS-1:0] irr_q, isr_q, mask_q;
   logic [N_LEVELS-1:0] win_hot, ack_vec, isr_clr;
   logic                win_valid, level_mode, init_done, init_clr;
   logic [LVL_W-1:0]    win_lvl;

   pic_ctl #(.N_LEVELS(N_LEVELS), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irr_q(irr_q), .isr_q(isr_q),
      .win_hot(win_hot), .win_valid(win_valid), .win_lvl(win_lvl),
      .mask_q(mask_q), .level_mode(level_mode), .init_done(init_done),
      .init_clr(init_clr), .ack_vec(ack_vec), .isr_clr(isr_clr)
   );

   pic_req #(.N_LEVELS(N_LEVELS)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .level_mode(level_mode), .init_clr(init_clr),
      .ack_vec(ack_vec), .irr_q(irr_q)
   );

   pic_isr #(.N_LEVELS(N_LEVELS)) u_isr (
      .clk(clk), .rst_n(rst_n), .init_clr(init_clr),
      .set_vec(ack_vec), .clr_vec(isr_clr), .isr_q(isr_q)
   );

   pic_prio #(.N_LEVELS(N_LEVELS), .LVL_W(LVL_W)) u_prio (
      .irr(irr_q), .isr(isr_q), .mask(mask_q),
      .win_hot(win_hot), .win_valid(win_valid), .win_lvl(win_lvl)
   );

   assign irq_out = win_valid & init_done;

   // R6: the request to the processor always has an unmasked source
   p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((irr_q & ~mask_q) != '0));

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] irq_in = 8'h00;
   logic       irq_out;

   always #2.5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .irq_out(irq_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model of the requirements
   logic [7:0] m_mask = 8'hFF, m_isr = 8'h00, m_irr = 8'h00, m_prev = 8'h00;
   bit         m_level = 0, m_poll = 0, m_rsel = 0, m_single = 0, m_need4 = 0;
   int         m_st = 0;   // 0 raw, 1..3 setup words, 4 running
   logic [7:0] cur_irq = 8'h00;
   logic [7:0] last_rd, exp_rd;

   function automatic int m_win();
      for (int i = 0; i < 8; i++) begin
         if (m_isr[i]) return -1;
         if (m_irr[i] && !m_mask[i]) return i;
      end
      return -1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input bit sel, input bit wr, input bit rd, input logic [7:0] d);
      int         w;
      bit         start;
      logic [7:0] ack, clr, rise, n_irr;
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = d; irq_in = cur_irq;
      #1;
      last_rd = bus_rdata;
      w = m_win();
      exp_rd = sel ? m_mask : (m_poll ? (w >= 0 ? (8'h80 | 8'(w)) : 8'h07)
                                      : (m_rsel ? m_isr : m_irr));
      start = wr && !sel && d[4];
      ack = (rd && !wr && !sel && m_poll && w >= 0) ? (8'h01 << w) : 8'h00;
      clr = 8'h00;
      if (wr && !sel && !d[4] && !d[3]) begin
         if (d[7:5] == 3'b011) clr = 8'h01 << d[2:0];
         else if (d[7:5] == 3'b001) clr = m_isr & (~m_isr + 8'h01);
      end
      rise = cur_irq & ~m_prev;
      if (start) n_irr = 8'h00;
      else if (m_level) n_irr = cur_irq;
      else n_irr = (m_irr | rise) & ~(ack & ~rise);
      @(posedge clk);
      m_irr = n_irr;
      m_prev = cur_irq;
      m_isr = start ? 8'h00 : ((m_isr | ack) & ~clr);
      if (start) begin
         m_st = 1; m_mask = 8'h00; m_poll = 0; m_rsel = 0;
         m_level = d[3]; m_single = d[1]; m_need4 = d[0];
      end else if (wr && sel) begin
         case (m_st)
            1: m_st = m_single ? (m_need4 ? 3 : 4) : 2;
            2: m_st = m_need4 ? 3 : 4;
            3: m_st = 4;
            default: m_mask = d;
         endcase
      end else if (wr && !sel && d[3]) begin
         m_poll = d[2];
         if (d[1]) m_rsel = d[0];
      end else if (rd && !sel && m_poll) begin
         m_poll = 0;
      end
      #1;
      // R6: output level every cycle
      check(irq_out == (m_st == 4 && m_win() >= 0), "R6 irq_out", irq_out,
            (m_st == 4 && m_win() >= 0));
   endtask

   task automatic wr_b(input bit sel, input logic [7:0] d);
      tick(sel, 1'b1, 1'b0, d);
   endtask

   task automatic rd_b(input bit sel, input string tag);
      tick(sel, 1'b0, 1'b1, 8'h00);
      check(last_rd === exp_rd, tag, last_rd, exp_rd);
   endtask

   task automatic idle();
      tick(1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic rd_fixed(input bit sel, input logic [7:0] want, input string tag);
      rd_b(sel, tag);
      check(last_rd === want, tag, last_rd, want);
   endtask

   task automatic rand_ops(input int n);
      for (int k = 0; k < n; k++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0, 1: begin cur_irq = cur_irq ^ (8'h01 << $urandom_range(0, 7)); idle(); end
            2: begin wr_b(0, 8'h0C); rd_b(0, "R7 random poll"); end
            3: wr_b(0, 8'h60 | 8'($urandom_range(0, 7)));   // R9
            4: wr_b(0, 8'h20);                               // R10
            5: wr_b(1, 8'($urandom) & 8'($urandom));         // R3
            6: wr_b(0, $urandom_range(0, 1) ? 8'h0B : 8'h0A);  // R11
            7: rd_b(0, "R11 random readback");
            8: rd_b(1, "R3 random mask readback");
            default: begin wr_b(0, 8'h0C); rd_b(0, "R8 random poll"); wr_b(0, 8'h20); end
         endcase
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check(irq_out == 1'b0, "R1 reset irq_out", irq_out, 0);
      rd_fixed(1, 8'hFF, "R1 reset mask");
      rd_fixed(0, 8'h00, "R1 reset request readback");
      // open mask before setup: output must stay low
      wr_b(1, 8'h00);
      cur_irq = 8'h01; idle(); idle();
      check(irq_out == 1'b0, "R1 no output before setup", irq_out, 0);

      // edge setup: start, base, cascade, mode
      wr_b(0, 8'h11); wr_b(1, 8'h20); wr_b(1, 8'h04); wr_b(1, 8'h01);
      rd_fixed(1, 8'h00, "R2 mask cleared by setup");
      check(irq_out == 1'b0, "R4 held input not relatched", irq_out, 0);
      cur_irq = 8'h09; idle();
      check(irq_out == 1'b1, "R4 rising edge latched", irq_out, 1);
      wr_b(1, 8'h08);
      check(irq_out == 1'b0, "R3 masked input blocked", irq_out, 0);
      rd_fixed(1, 8'h08, "R3 mask readback");
      wr_b(1, 8'h00);
      wr_b(0, 8'h0C); rd_fixed(0, 8'h83, "R7 poll level 3");
      rd_fixed(0, 8'h00, "R7 second read is request register");
      wr_b(0, 8'h0B); rd_fixed(0, 8'h08, "R11 in-service readback");
      rd_fixed(0, 8'h08, "R11 select persists");

      // nesting
      cur_irq = 8'h29; idle();
      check(irq_out == 1'b0, "R6 lower level blocked by service", irq_out, 0);
      cur_irq = 8'h2B; idle();
      check(irq_out == 1'b1, "R6 higher level preempts", irq_out, 1);
      wr_b(0, 8'h0C); rd_fixed(0, 8'h81, "R7 poll level 1");
      rd_fixed(0, 8'h0A, "R7 two levels in service");
      wr_b(0, 8'h20); rd_fixed(0, 8'h08, "R10 nonspecific clears highest");
      wr_b(0, 8'h66); rd_fixed(0, 8'h08, "R9 eoi to idle level");
      wr_b(0, 8'h63); rd_fixed(0, 8'h00, "R9 specific eoi");
      check(irq_out == 1'b1, "R6 level 5 presented", irq_out, 1);
      wr_b(0, 8'h0C); rd_fixed(0, 8'h85, "R7 poll level 5");
      wr_b(0, 8'h65);

      // empty and real level 7
      wr_b(0, 8'h0C); rd_fixed(0, 8'h07, "R8 empty poll");
      rd_fixed(0, 8'h00, "R8 in-service bit 7 clear");
      cur_irq = 8'hAB; idle();
      wr_b(0, 8'h0C); rd_fixed(0, 8'h87, "R8 real level 7");
      rd_fixed(0, 8'h80, "R8 in-service bit 7 set");
      wr_b(0, 8'h20);
      wr_b(0, 8'h0A);
      cur_irq = 8'h00; idle();
      rand_ops(500);

      // level setup, no cascade word, mode word present
      cur_irq = 8'h00;
      wr_b(0, 8'h1B); wr_b(1, 8'h20); wr_b(1, 8'h01); wr_b(1, 8'hF0);
      rd_fixed(1, 8'hF0, "R2 cascade word skipped");
      cur_irq = 8'h02; idle();
      check(irq_out == 1'b1, "R5 level request", irq_out, 1);
      wr_b(0, 8'h0C); rd_fixed(0, 8'h81, "R5 level poll");
      wr_b(0, 8'h0A); rd_fixed(0, 8'h02, "R5 request kept after ack");
      cur_irq = 8'h00; idle();
      rd_fixed(0, 8'h00, "R5 request follows input low");
      wr_b(0, 8'h61);
      rand_ops(500);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule